// File: doc/BRIEF.md
# I2C-Controlled Channel Enable Register

This block is an I2C target that owns one 8-bit channel-enable register. Each bit of the register drives the enable of one external pass switch. A set bit closes that channel and a clear bit opens it. Software on an I2C controller writes the register to pick any combination of channels, and can read it back to see which channels are closed.

The bus lines are sampled with a fast system clock. Each line goes through a two-flop synchronizer and then a persistence filter that rejects short spikes. After filtering, the block detects START, STOP and SCL edges and runs a byte engine. That engine receives the address, issues the acknowledge, accepts written bytes and shifts out read data. The target address is a fixed four-bit prefix followed by three strap pins.

SDA is open drain. The block only ever asserts a pull-low request, and the pad logic turns that request into the low drive. A synchronous active-low reset clears the register and aborts any transfer in progress.

Top module: `i2c_chan_enable`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal binary 1110 followed by strap_addr[2], strap_addr[1], strap_addr[0], sent MSB first; bit 0 of that byte is read (1) or write (0). For any other address the block gives no acknowledge, leaves SDA released and ignores every following bit until the next START or STOP.
- R2: After an acknowledged write address, each received data byte is acknowledged and loaded into the register; after several bytes the register holds the last one.
- R3: chan_en[n] equals register bit n, for every n, in any combination (1 = channel closed, 0 = open).
- R4: A written value reaches chan_en only when the block starts driving the acknowledge for that byte; during the eight data clocks chan_en keeps its old value.
- R5: A read returns the register MSB first. If the controller acknowledges, the same value is sent again. After a not-acknowledge the block releases SDA.
- R6: START (SDA falls while SCL is high) restarts the address phase from any state, including a repeated START in the middle of a transfer. STOP (SDA rises while SCL is high) returns the block to idle.
- R7: The acknowledge holds SDA low throughout the high phase of the ninth clock.
- R8: While rst_n is low, chan_en is 0 and SDA is released; the bus engine then restarts from idle.
- R9: A pulse on SCL or SDA lasting FILT_CYC-1 system clocks or less (50 ns at 100 MHz with the default of 6) is rejected and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL line level from the pad |
| sda_in | input | 1 | SDA line level from the pad |
| strap_addr | input | 3 | Low three address bits from strap pins |
| sda_pull_low | output | 1 | 1 = drive SDA low (open-drain request) |
| chan_en | output | 8 | Channel enables, bit n drives channel n |

## Verification
A wrong bit counter or state would show at the ports within a single byte time. The acknowledge would come on the wrong clock, or would be missing. An extra acknowledge could also hold SDA low where the controller expects it released. A register loaded at the wrong moment shows up on chan_en before the ninth clock instead of during it. A filter that passes spikes adds phantom clock edges or false START/STOP events, and that corrupts the byte read back on the very next transfer. Read data, acknowledge levels and the enable vector are all sampled during SCL high, in the same phase the controller itself uses.

// File: rtl/chen_pkg.sv
// Package: shared constants and types for the I2C channel-enable target.
// Assumes an 8-bit register (one byte per transfer) and 7-bit addressing.
package chen_pkg;
    localparam int BYTE_W     = 8;
    localparam int STRAP_W    = 3;
    localparam int PREFIX_W   = 7 - STRAP_W;
    localparam logic [PREFIX_W-1:0] ADDR_PREFIX = 4'b1110;
    localparam int CNT_W      = $clog2(BYTE_W + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_t;
endpackage

// File: rtl/chen_glitch_filter.sv
// Module: two-flop synchronizer followed by a persistence filter.
// The output takes a new level only after the synchronized input has held
// that level for FILT_CYC consecutive clocks. Assumes FILT_CYC >= 2.
module chen_glitch_filter #(
    parameter int   FILT_CYC = 6,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          out_q;

    // Purpose: bring the asynchronous pad level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {2{RST_VAL}};
        else        sync_q <= {sync_q[0], din};
    end

    // Purpose: count how long the input differs and commit once it persists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= RST_VAL;
        end else if (sync_q[1] == out_q) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            out_q <= sync_q[1];
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign dout = out_q;

    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> (out_q == $past(sync_q[1]))); // R9
endmodule

// File: rtl/chen_bus_events.sv
// Module: turns filtered SCL/SDA levels into one-cycle event pulses:
// START, STOP, SCL rising and SCL falling. Assumes both lines come through
// filters of equal latency, so their relative order is preserved.
module chen_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_evt,
    output logic stop_evt,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_p, sda_p;

    // Purpose: keep last-cycle line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    // Purpose: classify SDA edges during SCL high and SCL edges themselves.
    always_comb begin
        start_evt = scl_f && scl_p && sda_p && !sda_f;
        stop_evt  = scl_f && scl_p && !sda_p && sda_f;
        scl_rise  = scl_f && !scl_p;
        scl_fall  = !scl_f && scl_p;
    end
endmodule

// File: rtl/chen_target_fsm.sv
// Module: I2C target byte engine and the channel-enable register.
// Receives the address, acknowledges a match, loads written bytes at the
// acknowledge, and shifts out the register on reads. Assumes one-cycle
// event pulses from chen_bus_events and a filtered SDA level.
module chen_target_fsm
    import chen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_evt,
    input  logic               stop_evt,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_bit,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_pull,
    output logic [BYTE_W-1:0]  ctrl_reg
);
    localparam cnt_t CNT_FULL = cnt_t'(BYTE_W);
    localparam cnt_t CNT_LAST = cnt_t'(BYTE_W - 1);

    tgt_state_t        state_q;
    cnt_t              bit_cnt;
    logic [BYTE_W-1:0] rx_sr, tx_sr, ctrl_q;
    logic              pull_q, rw_q, mack_q;
    logic              addr_hit;

    // Purpose: compare the received address bits with prefix plus straps.
    assign addr_hit = (rx_sr[BYTE_W-1:1] == {ADDR_PREFIX, strap});

    // Purpose: sequence address, data and acknowledge bits of each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            ctrl_q  <= '0;
            pull_q  <= 1'b0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else if (start_evt) begin
            state_q <= ST_ADDR;
            bit_cnt <= '0;
            pull_q  <= 1'b0;
        end else if (stop_evt) begin
            state_q <= ST_IDLE;
            pull_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise && bit_cnt < CNT_FULL) begin
                        rx_sr   <= {rx_sr[BYTE_W-2:0], sda_bit};
                        bit_cnt <= bit_cnt + cnt_t'(1);
                    end else if (scl_fall && bit_cnt == CNT_FULL) begin
                        if (state_q == ST_WDATA) begin
                            ctrl_q  <= rx_sr;
                            pull_q  <= 1'b1;
                            state_q <= ST_WACK;
                        end else if (addr_hit) begin
                            rw_q    <= rx_sr[0];
                            pull_q  <= 1'b1;
                            state_q <= ST_ADDR_ACK;
                        end else begin
                            state_q <= ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            tx_sr   <= ctrl_q;
                            pull_q  <= !ctrl_q[BYTE_W-1];
                            state_q <= ST_RDATA;
                        end else begin
                            pull_q  <= 1'b0;
                            state_q <= ST_WDATA;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        pull_q  <= 1'b0;
                        bit_cnt <= '0;
                        state_q <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == CNT_LAST) begin
                            pull_q  <= 1'b0;
                            state_q <= ST_RACK;
                        end else begin
                            tx_sr   <= tx_sr << 1;
                            pull_q  <= !tx_sr[BYTE_W-2];
                            bit_cnt <= bit_cnt + cnt_t'(1);
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack_q <= !sda_bit;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            tx_sr   <= ctrl_q;
                            pull_q  <= !ctrl_q[BYTE_W-1];
                            bit_cnt <= '0;
                            state_q <= ST_RDATA;
                        end else begin
                            state_q <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_pull = pull_q;
    assign ctrl_reg = ctrl_q;

    AST_EN_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> (pull_q && state_q == ST_WACK)); // R4
    AST_SILENT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_IGNORE) |-> !pull_q); // R1
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state_q == ST_ADDR && bit_cnt == '0)); // R6
    AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK || state_q == ST_WACK) |-> pull_q); // R7
endmodule

// File: rtl/i2c_chan_enable.sv
// Module: top of the I2C channel-enable target. Filters both bus lines,
// derives bus events and runs the byte engine that owns the register.
// Assumes clk is fast enough that FILT_CYC cycles exceed 50 ns and a
// quarter SCL period at 400 kHz spans well over FILT_CYC + 4 cycles.
module i2c_chan_enable
    import chen_pkg::*;
#(
    parameter int FILT_CYC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap_addr,
    output logic               sda_pull_low,
    output logic [BYTE_W-1:0]  chan_en
);
    localparam int NLINE = 2;

    logic [NLINE-1:0] raw_lines, filt_lines;
    logic start_evt, stop_evt, scl_rise, scl_fall;

    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < NLINE; g++) begin : g_filt
        chen_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    chen_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (filt_lines[1]),
        .sda_f    (filt_lines[0]),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    chen_target_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_evt(start_evt),
        .stop_evt (stop_evt),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_bit  (filt_lines[0]),
        .strap    (strap_addr),
        .sda_pull (sda_pull_low),
        .ctrl_reg (chan_en)
    );
endmodule

// File: tb/i2c_chan_enable_test.sv
// Bench: directed I2C transfers against the channel-enable target.
module i2c_chan_enable_test;
    localparam int Q = 40;               // quarter SCL bit, in clocks
    localparam logic [7:0] AW = 8'hEA;   // 1110_101_0 with strap 101
    localparam logic [7:0] AR = 8'hEB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic sda_pull;
    logic [7:0] chan_en;
    wire  sda_line = sda_m & ~sda_pull;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_chan_enable uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_m),
        .sda_in      (sda_line),
        .strap_addr  (strap),
        .sda_pull_low(sda_pull),
        .chan_en     (chan_en)
    );

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitc(Q);
        scl_m = 1'b1; waitc(Q);
        sda_m = 1'b0; waitc(Q);
        scl_m = 1'b0; waitc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitc(Q);
        scl_m = 1'b1; waitc(Q);
        sda_m = 1'b1; waitc(Q);
    endtask

    // Send a byte; returns the ninth-clock SDA level, chan_en during bit 0
    // high and chan_en during the ninth clock high.
    task automatic send_byte(input logic [7:0] b, input bit glitch,
                             output logic ack, output logic [7:0] pre,
                             output logic [7:0] post);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitc(Q);
            if (glitch && i == 7) begin
                scl_m = 1'b1; waitc(5); scl_m = 1'b0; waitc(Q);
            end
            scl_m = 1'b1; waitc(Q);
            if (i == 0) pre = chan_en;
            if (glitch && i == 4) begin
                sda_m = 1'b0; waitc(5); sda_m = 1'b1;
            end
            waitc(Q);
            scl_m = 1'b0; waitc(Q);
        end
        sda_m = 1'b1; waitc(Q);
        scl_m = 1'b1; waitc(Q);
        ack = sda_line; post = chan_en;
        waitc(Q);
        scl_m = 1'b0; waitc(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            waitc(Q);
            scl_m = 1'b1; waitc(Q);
            d[i] = sda_line;
            waitc(Q);
            scl_m = 1'b0; waitc(Q);
        end
        sda_m = !mack; waitc(Q);
        scl_m = 1'b1; waitc(2 * Q);
        scl_m = 1'b0; sda_m = 1'b1; waitc(Q);
    endtask

    task automatic write_one(input logic [7:0] v);
        logic a; logic [7:0] p, q;
        bus_start();
        send_byte(AW, 1'b0, a, p, q);
        send_byte(v, 1'b0, a, p, q);
        bus_stop();
    endtask

    task automatic t_reset_state();
        waitc(10);
        check("R8 chan_en in reset", chan_en, 8'h00);
        check("R8 sda released in reset", {7'd0, sda_pull}, 8'h00);
        rst_n = 1'b1; waitc(10);
        check("R8 chan_en after reset", chan_en, 8'h00);
    endtask

    task automatic t_single_write();
        logic a; logic [7:0] p, q;
        bus_start();
        send_byte(AW, 1'b0, a, p, q);
        check("R1 address ack", {7'd0, a}, 8'h00);
        send_byte(8'hA5, 1'b0, a, p, q);
        check("R7 data ack low in ninth high", {7'd0, a}, 8'h00);
        check("R4 chan_en old during shift", p, 8'h00);
        check("R4 chan_en new at ack", q, 8'hA5);
        bus_stop();
        check("R3 enables equal register", chan_en, 8'hA5);
    endtask

    task automatic t_multi_write();
        logic a; logic [7:0] p, q;
        bus_start();
        send_byte(AW, 1'b0, a, p, q);
        send_byte(8'h11, 1'b0, a, p, q);
        check("R2 first byte ack", {7'd0, a}, 8'h00);
        send_byte(8'h22, 1'b0, a, p, q);
        check("R2 second byte ack", {7'd0, a}, 8'h00);
        check("R4 held previous byte during shift", p, 8'h11);
        send_byte(8'h83, 1'b0, a, p, q);
        check("R2 third byte ack", {7'd0, a}, 8'h00);
        bus_stop();
        check("R2 last byte wins", chan_en, 8'h83);
    endtask

    task automatic t_channels();
        write_one(8'h01);
        check("R3 only channel 0", chan_en, 8'h01);
        write_one(8'h80);
        check("R3 only channel 7", chan_en, 8'h80);
        write_one(8'h00);
        check("R3 all open", chan_en, 8'h00);
    endtask

    task automatic t_read();
        logic a; logic [7:0] p, q, d;
        write_one(8'h4C);
        bus_start();
        send_byte(AR, 1'b0, a, p, q);
        check("R1 read address ack", {7'd0, a}, 8'h00);
        recv_byte(1'b1, d);
        check("R5 first read byte", d, 8'h4C);
        recv_byte(1'b0, d);
        check("R5 repeated read byte", d, 8'h4C);
        check("R5 released after nack", {7'd0, sda_pull}, 8'h00);
        bus_stop();
        check("R5 read leaves register", chan_en, 8'h4C);
    endtask

    task automatic t_wrong_addr();
        logic a; logic [7:0] p, q;
        bus_start();
        send_byte(8'hE8, 1'b0, a, p, q);
        check("R1 mismatch no ack", {7'd0, a}, 8'h01);
        send_byte(8'hFF, 1'b0, a, p, q);
        check("R1 ignored byte no ack", {7'd0, a}, 8'h01);
        bus_stop();
        check("R1 ignored byte no effect", chan_en, 8'h4C);
    endtask

    task automatic t_rep_start();
        logic a; logic [7:0] p, q, d;
        bus_start();
        send_byte(AW, 1'b0, a, p, q);
        send_byte(8'h3C, 1'b0, a, p, q);
        bus_start();
        send_byte(AR, 1'b0, a, p, q);
        check("R6 repeated start address ack", {7'd0, a}, 8'h00);
        recv_byte(1'b0, d);
        check("R6 read after repeated start", d, 8'h3C);
        bus_stop();
    endtask

    task automatic t_glitch();
        logic a; logic [7:0] p, q;
        bus_start();
        send_byte(AW, 1'b0, a, p, q);
        send_byte(8'h5A, 1'b1, a, p, q);
        check("R9 ack despite spikes", {7'd0, a}, 8'h00);
        bus_stop();
        check("R9 spikes rejected", chan_en, 8'h5A);
    endtask

    task automatic t_reset_mid();
        logic a; logic [7:0] p, q;
        bus_start();
        send_byte(AW, 1'b0, a, p, q);
        sda_m = 1'b0; waitc(Q);
        rst_n = 1'b0; waitc(5);
        check("R8 reset clears enables", chan_en, 8'h00);
        check("R8 reset releases sda", {7'd0, sda_pull}, 8'h00);
        scl_m = 1'b1; sda_m = 1'b1; waitc(20);
        rst_n = 1'b1; waitc(20);
        write_one(8'h96);
        check("R8 engine usable after reset", chan_en, 8'h96);
    endtask

    initial begin
        t_reset_state();
        t_single_write();
        t_multi_write();
        t_channels();
        t_read();
        t_wrong_addr();
        t_rep_start();
        t_glitch();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule